// File: doc/BRIEF.md
# Two-Stage Instruction Prefetch Queue

This block keeps a multi-cycle processor core supplied with 16-bit program words. It reads memory ahead of the execute stage, but only in cycles when the core itself is not using the memory bus. Fetched words go into a two-stage queue. The word at the output stage is the one offered to the execute stage. A third holding register catches a fetched word only when the stages cannot take it directly.

The read interface has no wait states. In any cycle the queue raises its request, the memory returns the word at the requested address in that same cycle, and the queue captures it at the next clock edge. The execute stage takes a word by pulsing a consume strobe while the output is valid. On a change of flow, a flush empties the queue and moves the fetch pointer to a new address.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the output is not valid, and if the bus is free the first request targets START_ADDR.
- R2: A read is requested only in a cycle where bus_busy and flush are both low and there is room for the returned word.
- R3: The fetch address rises by 2 after every cycle in which a read was requested, and holds otherwise.
- R4: A word fetched into an empty queue first sits in stage 1. ex_valid rises after the second clock edge following its fetch.
- R5: Words reach ex_word in the order they were fetched, with no loss and no repeats.
- R6: The queue holds at most three words: both stages and the holding register. With three words held and no consume, no read is requested. With three words held and a consume, a read is requested in that same cycle.
- R7: A consume pulse while ex_valid is low has no effect.
- R8: A flush empties the queue and takes priority over a consume in the same cycle. It requests no read in its own cycle, and the next request targets flush_addr.
- R9: While ex_valid is high and no consume or flush occurs, ex_word stays the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | Core is using the memory bus this cycle |
| consume | input | 1 | Execute stage takes the word on ex_word |
| flush | input | 1 | Discard queued words and restart fetching |
| flush_addr | input | 16 | New fetch address used with flush |
| mem_req | output | 1 | Read request to program memory |
| mem_addr | output | 16 | Address of the read |
| mem_rdata | input | 16 | Word returned in the request cycle |
| ex_valid | output | 1 | ex_word holds a word ready to consume |
| ex_word | output | 16 | Word offered to the execute stage |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a consume and a new fetch while the queue is full: one word leaves, every stored word moves forward, and the returned word lands in the freed holding register. The second pair is a flush and a consume: the flush must win and the consume must be discarded. Both pairs are driven on purpose in directed phases and also arise often in a long run where busy, consume and flush are chosen at random. In every cycle a behavioural list model predicts the request, the address, the valid flag and the offered word, and the design is compared against it.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] START_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_busy,
  input  logic          consume,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          ex_valid,
  output logic [DW-1:0] ex_word
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [DW-1:0] st2, st1, hold;
  logic          v2, v1, vh;
  logic [AW-1:0] pc;

  logic take, s2_free, s1_go, s1_free, h_go, h_free, to_s1, to_h;

  assign take    = consume & v2 & ~flush;
  assign s2_free = ~v2 | take;
  assign s1_go   = v1 & s2_free;
  assign s1_free = ~v1 | s1_go;
  assign h_go    = vh & s1_free;
  assign h_free  = ~vh | h_go;
  assign mem_req = ~bus_busy & ~flush & h_free;
  assign to_s1   = mem_req & s1_free & ~vh;
  assign to_h    = mem_req & ~to_s1;

  assign mem_addr = pc;
  assign ex_valid = v2;
  assign ex_word  = st2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; v1 <= 1'b0; vh <= 1'b0;
      st2 <= '0; st1 <= '0; hold <= '0;
      pc <= START_ADDR;
    end else if (flush) begin
      v2 <= 1'b0; v1 <= 1'b0; vh <= 1'b0;
      pc <= flush_addr;
    end else begin
      if (s1_go) begin
        st2 <= st1; v2 <= 1'b1;
      end else if (take) v2 <= 1'b0;

      if (h_go) begin
        st1 <= hold; v1 <= 1'b1;
      end else if (to_s1) begin
        st1 <= mem_rdata; v1 <= 1'b1;
      end else if (s1_go) v1 <= 1'b0;

      if (to_h) begin
        hold <= mem_rdata; vh <= 1'b1;
      end else if (h_go) vh <= 1'b0;

      if (mem_req) pc <= pc + STEP;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !flush) |=> (mem_addr == $past(mem_addr) + STEP)); // R3
  AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && v1 && vh && !consume) |-> !mem_req); // R6
  AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    vh |-> v1); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ex_valid && !mem_req || !ex_valid)); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !consume && !flush) |=> (ex_valid && $stable(ex_word))); // R9
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !mem_req); // R2
endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  localparam logic [15:0] START = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_busy = 1'b1, consume = 1'b0, flush = 1'b0;
  logic [15:0] flush_addr = '0;
  logic mem_req, ex_valid;
  logic [15:0] mem_addr, mem_rdata, ex_word;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  assign mem_rdata = {mem_addr[7:0], mem_addr[15:8]} ^ 16'h5A3C;

  prefetch_queue #(.DW(16), .AW(16), .START_ADDR(START)) uut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .consume(consume),
    .flush(flush), .flush_addr(flush_addr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ex_valid(ex_valid),
    .ex_word(ex_word));

  logic [15:0] q[$];
  bit fresh[$];
  logic [15:0] fa = START;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit b, input bit c, input bit f, input logic [15:0] a);
    bit pres, ereq;
    int left;
    @(negedge clk);
    bus_busy = b; consume = c; flush = f; flush_addr = a;
    #5;
    pres = (q.size() > 0) && !fresh[0];
    left = q.size() - ((c && pres) ? 1 : 0);
    ereq = !b && !f && (left < 3);
    check(mem_req == ereq, "R2 R6 mem_req", 16'(mem_req), 16'(ereq));
    check(mem_addr == fa, "R3 R8 mem_addr", mem_addr, fa);
    check(ex_valid == pres, "R4 R7 R8 ex_valid", 16'(ex_valid), 16'(pres));
    if (pres) check(ex_word == q[0], "R5 R9 ex_word", ex_word, q[0]);
    if (f) begin
      q.delete(); fresh.delete(); fa = a;
    end else begin
      if (c && pres) begin void'(q.pop_front()); void'(fresh.pop_front()); end
      foreach (fresh[i]) fresh[i] = 1'b0;
      if (ereq) begin q.push_back(memf(fa)); fresh.push_back(1'b1); fa = fa + 16'd2; end
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_busy = 1'b0;
    #5;
    check(!ex_valid, "R1 ex_valid after reset", 16'(ex_valid), 16'h0);
    check(mem_req, "R1 mem_req after reset", 16'(mem_req), 16'h1);
    check(mem_addr == START, "R1 mem_addr after reset", mem_addr, START);
    bus_busy = 1'b1;
    // R4 R6: fill with no consume, queue must stop at three words
    repeat (6) step(0, 0, 0, 0);
    check(q.size() == 3, "R6 model fill level", 16'(q.size()), 16'd3);
    // R6: consume and fetch in the same cycle while full
    repeat (8) step(0, 1, 0, 0);
    // R2: busy bus blocks fetches while words drain
    repeat (5) step(1, 1, 0, 0);
    // R7: consume on empty output is ignored
    step(0, 0, 1, 16'h2000);
    step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    repeat (4) step(0, 0, 0, 0);
    // R8: flush with consume in same cycle
    step(0, 1, 1, 16'h4000);
    step(0, 1, 0, 0);
    // R9: hold while not consumed
    repeat (4) step(1, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit rb, rc, rf;
      rb = ($urandom_range(0, 2) == 0);
      rc = ($urandom_range(0, 1) == 0);
      rf = ($urandom_range(0, 40) == 0);
      step(rb, rc, rf, 16'($urandom_range(0, 16'h7FFF)) & 16'hFFFE);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule